// File: doc/BRIEF.md
# Indexed Register Window with Clock Calibration Counter

This block is the byte-wide register file of a two-channel disk controller. Each channel has an eight-byte window. Software reaches the internal registers of a window in two steps. It first writes a register number into the window's index port. It then reads or writes the window's data port, and that access reaches the numbered register. Behind the two windows sit a control register, the PLL divider settings, a cable-type status bit for each channel, and a bank of timing bytes for each drive.

The block also holds a 30-bit calibration counter that counts down. It is clocked from a reference-clock enable pulse and runs only while a test-mode bit is set. Software takes a counter reading, waits a known time, and takes a second reading; the difference gives the frequency of the reference clock. The counter is spread over four byte locations in the two windows. These byte reads are not atomic, so software re-reads the counter when a carry may have rippled between two of its byte reads.

Top module: `regwin_top`

## Requirements
- R1: The index port of each window is at byte offset 1 and the data port at byte offset 3. The secondary window starts at byte address 8, so its ports are at addresses 9 and 11. A read of any other offset returns zero, and a write to any other offset changes nothing.
- R2: A write to an index port stores the written byte. A read of that port returns the stored byte. Each window keeps its own index, and data port accesses reach the register selected by that window's index.
- R3: While the test-mode bit is set, the counter decreases by one on each clock edge where ref_tick is high. From zero it wraps to all ones.
- R4: Register 0x01 of the primary window is a full 8-bit read/write control register. Its bit 6 is the test-mode bit. While bit 6 is clear, the counter holds its value.
- R5: The counter is read through four locations. In the primary window, index 0x20 gives bits 7:0 and index 0x21 gives bits 14:8 in the low seven bits. In the secondary window, index 0x20 gives bits 22:15 and index 0x21 gives bits 29:23. Bit 7 of each 0x21 byte reads 0, and counter bits above CNT_W read 0.
- R6: Registers 0x02 (feedback value) and 0x03 (reference divider) of the secondary window are 8-bit read/write.
- R7: Register 0x0b of each window reads back that window's cable_slow pin in bit 2. All other bits of 0x0b read 0.
- R8: Each window holds eight timing bytes for drive 0 at indices 0x0c–0x13 and eight for drive 1 at indices 0x14–0x1b. All of them are read/write, and every byte is kept apart from every other byte, in both windows.
- R9: Writes to the counter bytes and to 0x0b are ignored. Indices that are not implemented in a window read as zero and ignore writes. These include 0x01 in the secondary window, 0x02 and 0x03 in the primary window, and every index of 0x22 or above.
- R10: After reset, both index registers, the control register, the PLL settings and every timing byte are zero, and the counter is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| cable_slow | input | NUM_CH | Cable type for each channel. 1 means a cable unfit for fast modes. |
| bus_addr | input | ADDR_W | Byte address within the two windows |
| bus_wr | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr. It is combinational. |

## Verification
The bench builds two instances that share all inputs. The first uses the default 30-bit counter, so the bit split across all four counter bytes is checked against counts near the top of the range. The second uses CNT_W = 10. Its counter reaches zero after 1023 reference ticks and then wraps to all ones, and its counter bits above the counter width read back as zero. The wrap is out of reach of any short run with the full-width counter.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

   // indices decoded by the data port
   localparam logic [7:0] IDX_CTRL     = 8'h01;
   localparam logic [7:0] IDX_PLL_F    = 8'h02;
   localparam logic [7:0] IDX_PLL_R    = 8'h03;
   localparam logic [7:0] IDX_CABLE    = 8'h0b;
   localparam logic [7:0] IDX_TIM_BASE = 8'h0c;
   localparam logic [7:0] IDX_CNT_LO   = 8'h20;
   localparam logic [7:0] IDX_CNT_HI   = 8'h21;

   localparam int TEST_BIT  = 6;
   localparam int CABLE_BIT = 2;
   localparam int OFS_INDEX = 1;
   localparam int OFS_DATA  = 3;
   localparam int CH_PRI    = 0;
   localparam int CH_SEC    = 1;
   localparam int CNT_SPAN  = 30;

   typedef enum logic [1:0] {
      PORT_NONE,
      PORT_INDEX,
      PORT_DATA
   } port_e;

   function automatic port_e port_of(input int unsigned ofs);
      if (ofs == OFS_INDEX)     return PORT_INDEX;
      else if (ofs == OFS_DATA) return PORT_DATA;
      else                      return PORT_NONE;
   endfunction

   // byte view of the zero-extended calibration count
   function automatic logic [7:0] cnt_byte(input logic [CNT_SPAN-1:0] c,
                                           input logic sec, input logic hi);
      logic [7:0] b;
      case ({sec, hi})
         2'b00:   b = c[7:0];
         2'b01:   b = {1'b0, c[14:8]};
         2'b10:   b = c[22:15];
         default: b = {1'b0, c[29:23]};
      endcase
      return b;
   endfunction

endpackage

// File: rtl/regwin_cal_counter.sv
module regwin_cal_counter #(
   parameter int CNT_W = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   output logic [CNT_W-1:0] count
);

   if (CNT_W < 1) begin : g_bad_width
      $error("regwin_cal_counter: CNT_W must be positive");
   end

   // wraps from zero to all ones by modular subtraction
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '1;
      else if (run && tick)
         count <= count - 1'b1;
   end

endmodule

// File: rtl/regwin_chan.sv
module regwin_chan #(
   parameter int         NUM_DRV     = 2,
   parameter int         TIM_PER_DRV = 8,
   parameter int         DRV_STRIDE  = 8,
   parameter logic [7:0] TIM_BASE    = 8'h0c
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic       data_wr,
   input  logic [7:0] wdata,
   output logic [7:0] index,
   output logic       tim_hit,
   output logic [7:0] tim_rdata
);

   localparam int RW = $clog2(TIM_PER_DRV);

   if (TIM_PER_DRV < 2 || TIM_PER_DRV > DRV_STRIDE) begin : g_bad_bank
      $error("regwin_chan: TIM_PER_DRV must be 2..DRV_STRIDE");
   end
   if (int'(TIM_BASE) + NUM_DRV * DRV_STRIDE > 8'h20) begin : g_bad_span
      $error("regwin_chan: timing banks collide with counter indices");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         index <= '0;
      else if (idx_wr)
         index <= wdata;
   end

   logic [NUM_DRV-1:0]      hit_v;
   logic [NUM_DRV-1:0][7:0] rd_v;

   for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
      logic [7:0] bank [TIM_PER_DRV];
      logic [7:0] rel;

      assign rel      = index - 8'(int'(TIM_BASE) + d * DRV_STRIDE);
      assign hit_v[d] = rel < 8'(TIM_PER_DRV);
      assign rd_v[d]  = hit_v[d] ? bank[rel[RW-1:0]] : 8'h00;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int r = 0; r < TIM_PER_DRV; r++) bank[r] <= '0;
         end else if (data_wr && hit_v[d]) begin
            bank[rel[RW-1:0]] <= wdata;
         end
      end
   end

   always_comb begin
      tim_rdata = '0;
      for (int d = 0; d < NUM_DRV; d++) tim_rdata = tim_rdata | rd_v[d];
      tim_hit = |hit_v;
   end

endmodule

// File: rtl/regwin_top.sv
module regwin_top
   import regwin_pkg::*;
#(
   parameter int  CNT_W       = 30,
   parameter int  NUM_CH      = 2,
   parameter int  CH_STRIDE   = 8,
   parameter int  NUM_DRV     = 2,
   parameter int  TIM_PER_DRV = 8,
   parameter int  DRV_STRIDE  = 8,
   localparam int ADDR_W      = $clog2(NUM_CH * CH_STRIDE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic [NUM_CH-1:0] cable_slow,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata
);

   localparam int OFS_W = $clog2(CH_STRIDE);
   localparam int CH_W  = ADDR_W - OFS_W;

   if (NUM_CH != 2) begin : g_bad_ch
      $error("regwin_top: counter split needs exactly two channels");
   end
   if (CH_STRIDE < 4 || (1 << OFS_W) != CH_STRIDE) begin : g_bad_stride
      $error("regwin_top: CH_STRIDE must be a power of two >= 4");
   end
   if (CNT_W < 1 || CNT_W > CNT_SPAN) begin : g_bad_cnt
      $error("regwin_top: CNT_W must be 1..30");
   end

   logic [CH_W-1:0]  ch_sel;
   logic [OFS_W-1:0] ofs;
   port_e            port;

   assign ch_sel = bus_addr[ADDR_W-1:OFS_W];
   assign ofs    = bus_addr[OFS_W-1:0];
   assign port   = port_of(int'(ofs));

   logic [7:0]              ctrl_q, pll_f_q, pll_r_q;
   logic                    test_run;
   logic [CNT_W-1:0]        cnt_q;
   logic [CNT_SPAN-1:0]     cnt_ext;
   logic [NUM_CH-1:0][7:0]  ch_index;
   logic [NUM_CH-1:0][7:0]  ch_rdata;
   logic [NUM_CH-1:0]       data_wr_v;

   assign test_run = ctrl_q[TEST_BIT];
   assign cnt_ext  = CNT_SPAN'(cnt_q);

   regwin_cal_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (test_run),
      .tick  (ref_tick),
      .count (cnt_q)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic       idx_wr, tim_hit;
      logic [7:0] tim_rd, reg_rd;

      assign idx_wr       = bus_wr && (ch_sel == CH_W'(c)) && (port == PORT_INDEX);
      assign data_wr_v[c] = bus_wr && (ch_sel == CH_W'(c)) && (port == PORT_DATA);

      regwin_chan #(
         .NUM_DRV     (NUM_DRV),
         .TIM_PER_DRV (TIM_PER_DRV),
         .DRV_STRIDE  (DRV_STRIDE),
         .TIM_BASE    (IDX_TIM_BASE)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .idx_wr    (idx_wr),
         .data_wr   (data_wr_v[c]),
         .wdata     (bus_wdata),
         .index     (ch_index[c]),
         .tim_hit   (tim_hit),
         .tim_rdata (tim_rd)
      );

      always_comb begin
         case (ch_index[c])
            IDX_CTRL:   reg_rd = (c == CH_PRI) ? ctrl_q  : 8'h00;
            IDX_PLL_F:  reg_rd = (c == CH_SEC) ? pll_f_q : 8'h00;
            IDX_PLL_R:  reg_rd = (c == CH_SEC) ? pll_r_q : 8'h00;
            IDX_CABLE:  reg_rd = 8'(cable_slow[c]) << CABLE_BIT;
            IDX_CNT_LO: reg_rd = cnt_byte(cnt_ext, c == CH_SEC, 1'b0);
            IDX_CNT_HI: reg_rd = cnt_byte(cnt_ext, c == CH_SEC, 1'b1);
            default:    reg_rd = tim_hit ? tim_rd : 8'h00;
         endcase
      end

      always_comb begin
         case (port)
            PORT_INDEX: ch_rdata[c] = ch_index[c];
            PORT_DATA:  ch_rdata[c] = reg_rd;
            default:    ch_rdata[c] = 8'h00;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         pll_f_q <= '0;
         pll_r_q <= '0;
      end else begin
         if (data_wr_v[CH_PRI] && ch_index[CH_PRI] == IDX_CTRL)
            ctrl_q <= bus_wdata;
         if (data_wr_v[CH_SEC] && ch_index[CH_SEC] == IDX_PLL_F)
            pll_f_q <= bus_wdata;
         if (data_wr_v[CH_SEC] && ch_index[CH_SEC] == IDX_PLL_R)
            pll_r_q <= bus_wdata;
      end
   end

   assign bus_rdata = ch_rdata[ch_sel];

endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
   parameter int CNT_W  = 30,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_tick,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic              cable0,
   input logic [7:0]        idx0,
   input logic              run,
   input logic [CNT_W-1:0]  cnt
);

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ref_tick) |=> cnt == CNT_W'($past(cnt) - 1'b1)); // R3

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(run && ref_tick) |=> $stable(cnt)); // R4

   AST_IDX_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(1)) |=> idx0 == $past(bus_wdata)); // R2

   AST_CABLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(3) && idx0 == 8'h0b) |-> bus_rdata == {5'b0, cable0, 2'b00}); // R7

   AST_UNIMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(3) && idx0 >= 8'h22) |-> bus_rdata == 8'h00); // R9

   AST_CNT_HI_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(3) && idx0 == 8'h21) |-> bus_rdata[7] == 1'b0); // R5

endmodule

bind regwin_top regwin_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_tick  (ref_tick),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .cable0    (cable_slow[0]),
   .idx0      (ch_index[0]),
   .run       (test_run),
   .cnt       (cnt_q)
);

// File: tb/test_regwin_top.sv
module test_regwin_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] cable = 2'b00;
   logic [3:0] addr = '0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata_w, rdata_n;

   int checks = 0;
   int failures = 0;
   int unsigned ticks_run = 0;
   bit test_on = 1'b0;

   always #4 clk = ~clk;

   regwin_top i_regwin_top (
      .clk(clk), .rst_n(rst_n), .ref_tick(tick), .cable_slow(cable),
      .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata_w));

   regwin_top #(.CNT_W(10)) i_regwin_top_w10 (
      .clk(clk), .rst_n(rst_n), .ref_tick(tick), .cable_slow(cable),
      .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata_n));

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [7:0] dw, output logic [7:0] dn);
      @(negedge clk);
      addr = a; wr = 1'b0;
      #1;
      dw = rdata_w; dn = rdata_n;
   endtask

   task automatic reg_write(input bit sec, input logic [7:0] idx, input logic [7:0] d);
      bus_write(sec ? 4'd9 : 4'd1, idx);
      bus_write(sec ? 4'd11 : 4'd3, d);
   endtask

   task automatic reg_read(input bit sec, input logic [7:0] idx, output logic [7:0] dw, output logic [7:0] dn);
      bus_write(sec ? 4'd9 : 4'd1, idx);
      bus_read(sec ? 4'd11 : 4'd3, dw, dn);
   endtask

   task automatic chk_reg(input string req, input bit sec, input logic [7:0] idx, input logic [7:0] exp);
      logic [7:0] dw, dn;
      reg_read(sec, idx, dw, dn);
      chk(req, $sformatf("wide ch%0d idx %02h", sec, idx), dw, exp);
      chk(req, $sformatf("w10 ch%0d idx %02h", sec, idx), dn, exp);
   endtask

   task automatic run_ticks(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
      if (test_on) ticks_run += n;
   endtask

   // R5 split: primary 0x20 -> [7:0], 0x21 -> [14:8]; secondary 0x20 -> [22:15], 0x21 -> [29:23]
   function automatic logic [7:0] split_byte(input logic [29:0] c, input bit sec, input bit hi);
      if (!sec && !hi) return c[7:0];
      if (!sec &&  hi) return {1'b0, c[14:8]};
      if ( sec && !hi) return c[22:15];
      return {1'b0, c[29:23]};
   endfunction

   task automatic check_counter(input string req);
      logic [29:0] ew, en;
      logic [7:0]  dw, dn;
      ew = 30'h3FFF_FFFF - 30'(ticks_run);
      en = 30'(10'h3FF - 10'(ticks_run));
      for (int s = 0; s < 2; s++) begin
         for (int h = 0; h < 2; h++) begin
            reg_read(s[0], h[0] ? 8'h21 : 8'h20, dw, dn);
            chk(req, $sformatf("wide count byte s%0d h%0d", s, h), dw, split_byte(ew, s[0], h[0]));
            chk(req, $sformatf("w10 count byte s%0d h%0d", s, h), dn, split_byte(en, s[0], h[0]));
         end
      end
   endtask

   task automatic t_reset;
      logic [7:0] dw, dn;
      bus_read(4'd1, dw, dn); chk("R10", "pri index", dw, 8'h00);
      bus_read(4'd9, dw, dn); chk("R10", "sec index", dw, 8'h00);
      chk_reg("R10", 1'b0, 8'h01, 8'h00);
      chk_reg("R10", 1'b1, 8'h02, 8'h00);
      chk_reg("R10", 1'b1, 8'h03, 8'h00);
      chk_reg("R10", 1'b0, 8'h0c, 8'h00);
      chk_reg("R10", 1'b1, 8'h1b, 8'h00);
      check_counter("R10");
   endtask

   task automatic t_layout;
      logic [7:0] dw, dn;
      bus_write(4'd1, 8'h5C);
      bus_read(4'd1, dw, dn); chk("R2", "pri index readback", dw, 8'h5C);
      bus_write(4'd9, 8'hA7);
      bus_read(4'd9, dw, dn); chk("R2", "sec index readback", dw, 8'hA7);
      bus_read(4'd1, dw, dn); chk("R2", "pri index kept", dw, 8'h5C);
      bus_write(4'd0, 8'h33);
      bus_write(4'd2, 8'h44);
      bus_write(4'd10, 8'h55);
      bus_read(4'd1, dw, dn); chk("R1", "pri index after stray writes", dw, 8'h5C);
      bus_read(4'd9, dw, dn); chk("R1", "sec index after stray writes", dw, 8'hA7);
      bus_read(4'd0, dw, dn); chk("R1", "offset 0 reads zero", dw, 8'h00);
      bus_read(4'd2, dw, dn); chk("R1", "offset 2 reads zero", dw, 8'h00);
      bus_read(4'd15, dw, dn); chk("R1", "offset 15 reads zero", dw, 8'h00);
   endtask

   task automatic t_hold;
      reg_write(1'b0, 8'h01, 8'h1A);
      chk_reg("R4", 1'b0, 8'h01, 8'h1A);
      run_ticks(40);
      check_counter("R4");
   endtask

   task automatic t_run_wrap;
      reg_write(1'b0, 8'h01, 8'h5A);
      test_on = 1'b1;
      chk_reg("R4", 1'b0, 8'h01, 8'h5A);
      run_ticks(1023);
      check_counter("R3");
      run_ticks(1);
      check_counter("R3");
      run_ticks(300);
      check_counter("R5");
      reg_write(1'b0, 8'h01, 8'h1A);
      test_on = 1'b0;
      run_ticks(25);
      check_counter("R4");
   endtask

   task automatic t_pll;
      reg_write(1'b1, 8'h02, 8'h7F);
      reg_write(1'b1, 8'h03, 8'h0D);
      chk_reg("R6", 1'b1, 8'h02, 8'h7F);
      chk_reg("R6", 1'b1, 8'h03, 8'h0D);
      reg_write(1'b0, 8'h02, 8'h33);
      chk_reg("R9", 1'b0, 8'h02, 8'h00);
      chk_reg("R6", 1'b1, 8'h02, 8'h7F);
   endtask

   task automatic t_cable;
      cable = 2'b01;
      chk_reg("R7", 1'b0, 8'h0b, 8'h04);
      chk_reg("R7", 1'b1, 8'h0b, 8'h00);
      cable = 2'b10;
      chk_reg("R7", 1'b0, 8'h0b, 8'h00);
      chk_reg("R7", 1'b1, 8'h0b, 8'h04);
      reg_write(1'b0, 8'h0b, 8'hFF);
      chk_reg("R9", 1'b0, 8'h0b, 8'h00);
   endtask

   task automatic t_timing;
      reg_write(1'b0, 8'h0c, 8'h11);
      reg_write(1'b0, 8'h13, 8'h22);
      reg_write(1'b0, 8'h14, 8'h33);
      reg_write(1'b0, 8'h1b, 8'h44);
      reg_write(1'b1, 8'h0c, 8'h99);
      reg_write(1'b1, 8'h17, 8'h66);
      chk_reg("R8", 1'b0, 8'h0c, 8'h11);
      chk_reg("R8", 1'b0, 8'h13, 8'h22);
      chk_reg("R8", 1'b0, 8'h14, 8'h33);
      chk_reg("R8", 1'b0, 8'h1b, 8'h44);
      chk_reg("R8", 1'b1, 8'h0c, 8'h99);
      chk_reg("R8", 1'b1, 8'h17, 8'h66);
      chk_reg("R8", 1'b0, 8'h17, 8'h00);
      chk_reg("R8", 1'b1, 8'h13, 8'h00);
   endtask

   task automatic t_readonly;
      reg_write(1'b0, 8'h20, 8'h00);
      reg_write(1'b1, 8'h21, 8'h00);
      check_counter("R9");
      reg_write(1'b0, 8'h40, 8'h55);
      chk_reg("R9", 1'b0, 8'h40, 8'h00);
      reg_write(1'b1, 8'h01, 8'h40);
      chk_reg("R9", 1'b1, 8'h01, 8'h00);
      chk_reg("R9", 1'b0, 8'h01, 8'h1A);
      run_ticks(10);
      check_counter("R9");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_layout();
      t_hold();
      t_run_wrap();
      t_pll();
      t_cable();
      t_timing();
      t_readonly();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule